// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a processor bus and an on-chip flash array while the array is being rewritten in system. Software writes single-byte command codes on the bus. Each command either changes what a bus read returns (array bytes or a status byte), clears sticky error flags, or opens a two-write sequence that starts a program or a block-erase operation. When an operation starts, reads switch to status by themselves. They stay on status until software asks for the array again.

For self-contained testing, the datapath holds a small byte array model. The model has a parameterised operation latency, an erase block size and a fault-injection input. Programming can only clear bits. A programmed byte that does not read back as the requested value raises the program-error flag. An erase sets every byte of the addressed block to 0xFF. A ready/busy output reports whether an operation is in progress.

Top module: `flashCmdCtrl`

## Requirements
- R1: After reset, reads return array contents, `readyBusy` is 1, both error flags are clear, and every array byte reads 0xFF.
- R2: Writing 0xFF when no sequence is open selects array reads: `busRdata` shows the byte at `busAddr`. This holds until another mode-changing command is written.
- R3: Writing 0x70 selects status reads. The status byte has bit 7 = ready (1 when idle), bit 5 = erase error, bit 4 = program error, and all other bits 0.
- R4: Writing 0x50 clears the program-error and erase-error flags and leaves the read mode unchanged.
- R5: A write of 0x40 followed by a write carrying address and data starts a program. When it finishes, the addressed byte holds old AND data. The second write switches reads to status.
- R6: A write of 0x20 followed by a write of 0xD0 starts an erase. The second write's address (any address in the block, normally its highest) selects a block of 2^BLOCK_W bytes, and every byte of that block becomes 0xFF. Bytes outside the block are unchanged.
- R7: `readyBusy` and status bit 7 are 0 for exactly OP_LAT clock cycles after the edge that accepts the second write of a sequence, then return to 1.
- R8: While busy, bus writes have no effect and reads return the status byte whatever the selected mode.
- R9: If the second write of an erase sequence carries any value other than 0xD0, no operation starts. Both error flags are set, and reads switch to status.
- R10: A program whose result differs from the requested data (an attempt to turn a 0 bit into 1) sets the program-error flag.
- R11: After an operation ends, reads keep returning status until 0xFF is written.
- R12: A first-cycle write of any code other than 0xFF, 0x70, 0x50, 0x40 or 0x20 is ignored.
- R13: When `injectFail` is 1 on the second write of a sequence, the operation leaves the array unchanged. It sets the program-error flag for a program and the erase-error flag for an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe, one write per cycle |
| busAddr | input | ADDR_W | Bus address for writes and reads |
| busWdata | input | 8 | Bus write data (command code or program data) |
| injectFail | input | 1 | Fault injection, sampled with the second write of a sequence |
| busRdata | output | 8 | Read data: array byte or status byte |
| readyBusy | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
Several rules are checked on every cycle by the assertions. The decoder never raises two strobes at once. The pending sequence and read mode hold still while busy. Any sequence's second write forces status reads. Accepting an operation raises busy, and the countdown stays within OP_LAT. The clear and sequence-error strobes land on the flags one cycle later. A busy output always presents a status byte with bit 7 low. Only the bench scenarios can show the byte values the array ends up with: the AND rule for programming, the block boundaries of an erase, the effect of injected faults, and that status reads persist until 0xFF is written. The bench compares these against its own model on every clock.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_PROGRAM     = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_PROG  = 2'd1,
    PEND_ERASE = 2'd2
  } pendT;

  typedef struct packed {
    logic startProg;
    logic startErase;
    logic seqErr;
    logic clrErr;
  } strobeT;

endpackage

// File: rtl/flashCmdControl.sv
module flashCmdControl
  import flashCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [7:0] busWdata,
  input  logic       busy,
  output strobeT     strobes,
  output logic       readStatus
);

  pendT pend, nextPend;
  logic nextReadStatus;

  always_comb begin
    strobes        = '0;
    nextPend       = pend;
    nextReadStatus = readStatus;
    if (busWe && !busy) begin
      unique case (pend)
        PEND_PROG: begin
          strobes.startProg = 1'b1;
          nextReadStatus    = 1'b1;
          nextPend          = PEND_NONE;
        end
        PEND_ERASE: begin
          if (busWdata == CMD_CONFIRM) strobes.startErase = 1'b1;
          else                         strobes.seqErr     = 1'b1;
          nextReadStatus = 1'b1;
          nextPend       = PEND_NONE;
        end
        default: begin
          case (busWdata)
            CMD_READ_ARRAY:  nextReadStatus = 1'b0;
            CMD_READ_STATUS: nextReadStatus = 1'b1;
            CMD_CLEAR_ERR:   strobes.clrErr = 1'b1;
            CMD_PROGRAM:     nextPend       = PEND_PROG;
            CMD_ERASE:       nextPend       = PEND_ERASE;
            default:         ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend       <= PEND_NONE;
      readStatus <= 1'b0;
    end else begin
      pend       <= nextPend;
      readStatus <= nextReadStatus;
    end
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.startProg, strobes.startErase, strobes.seqErr, strobes.clrErr}))
    else $error("more than one control strobe");

  assert_busy_ignores_writes_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(pend) && $stable(readStatus)))
    else $error("control state moved while busy");

  assert_auto_status_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startProg || strobes.startErase || strobes.seqErr) |=> readStatus)
    else $error("second write did not select status reads");

endmodule

// File: rtl/flashArrayModel.sv
module flashArrayModel
  import flashCmdPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 4,
  parameter int OP_LAT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              injectFail,
  output logic [7:0]        arrayByte,
  output logic              busy,
  output logic              progErr,
  output logic              eraseErr
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_W   = $clog2(OP_LAT + 1);
  localparam int BLKID_W = ADDR_W - BLOCK_W;
  localparam logic [CNT_W-1:0] LAT = CNT_W'(OP_LAT);

  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              opIsErase;
  logic              opFail;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic [7:0]        progResult;
  logic              finishing;

  function automatic logic [BLKID_W-1:0] blockOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLOCK_W];
  endfunction

  assign arrayByte  = mem[busAddr];
  assign progResult = mem[opAddr] & opData;
  assign finishing  = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      busy      <= 1'b0;
      cnt       <= '0;
      opIsErase <= 1'b0;
      opFail    <= 1'b0;
      opAddr    <= '0;
      opData    <= '0;
      progErr   <= 1'b0;
      eraseErr  <= 1'b0;
    end else begin
      if (strobes.startProg || strobes.startErase) begin
        busy      <= 1'b1;
        cnt       <= LAT;
        opIsErase <= strobes.startErase;
        opAddr    <= busAddr;
        opData    <= busWdata;
        opFail    <= injectFail;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (finishing) busy <= 1'b0;
      end

      if (finishing) begin
        if (opIsErase) begin
          if (opFail) eraseErr <= 1'b1;
          else begin
            for (int i = 0; i < DEPTH; i++)
              if (blockOf(ADDR_W'(i)) == blockOf(opAddr)) mem[i] <= 8'hFF;
          end
        end else begin
          if (opFail) progErr <= 1'b1;
          else begin
            mem[opAddr] <= progResult;
            if (progResult != opData) progErr <= 1'b1;
          end
        end
      end

      if (strobes.seqErr) begin
        progErr  <= 1'b1;
        eraseErr <= 1'b1;
      end
      if (strobes.clrErr) begin
        progErr  <= 1'b0;
        eraseErr <= 1'b0;
      end
    end
  end

  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startProg || strobes.startErase) |=> busy)
    else $error("operation accepted but not busy");

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAT)
    else $error("latency counter out of range");

  assert_clear_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrErr |=> (!progErr && !eraseErr))
    else $error("error flags not cleared");

  assert_seq_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.seqErr |=> (progErr && eraseErr && !busy))
    else $error("sequence error not flagged");

endmodule

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 4,
  parameter int OP_LAT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              injectFail,
  output logic [7:0]        busRdata,
  output logic              readyBusy
);

  strobeT     strobes;
  logic       readStatus;
  logic       busy;
  logic       progErr;
  logic       eraseErr;
  logic [7:0] arrayByte;
  logic [7:0] statusByte;

  flashCmdControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .busy       (busy),
    .strobes    (strobes),
    .readStatus (readStatus)
  );

  flashArrayModel #(
    .ADDR_W  (ADDR_W),
    .BLOCK_W (BLOCK_W),
    .OP_LAT  (OP_LAT)
  ) u_array (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .injectFail (injectFail),
    .arrayByte  (arrayByte),
    .busy       (busy),
    .progErr    (progErr),
    .eraseErr   (eraseErr)
  );

  assign statusByte = {~busy, 1'b0, eraseErr, progErr, 4'b0000};
  assign busRdata   = (busy || readStatus) ? statusByte : arrayByte;
  assign readyBusy  = ~busy;

  assert_busy_reads_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    !readyBusy |-> (busRdata[7] == 1'b0 && busRdata[6] == 1'b0 && busRdata[3:0] == 4'h0))
    else $error("busy read did not return status");

endmodule

// File: tb/test_flashCmdCtrl.sv
module test_flashCmdCtrl;

  localparam int ADDR_W  = 6;
  localparam int BLOCK_W = 4;
  localparam int OP_LAT  = 4;
  localparam int DEPTH   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              busWe;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        busWdata;
  logic              injectFail;
  logic [7:0]        busRdata;
  logic              readyBusy;

  always #4 clk = ~clk;

  flashCmdCtrl #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .OP_LAT(OP_LAT)) i_flashCmdCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .injectFail(injectFail), .busRdata(busRdata), .readyBusy(readyBusy)
  );

  int    mem [DEPTH];
  bit    mStatus, mErase, mFail, sr4, sr5;
  int    mPend, mCnt, mAddr, mData;
  int    vectors = 0, errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  function automatic int expRead(int a);
    if (mCnt > 0 || mStatus)
      return ((mCnt > 0) ? 0 : 128) | (sr5 ? 32 : 0) | (sr4 ? 16 : 0);
    return mem[a];
  endfunction

  task automatic modelReset();
    foreach (mem[i]) mem[i] = 255;
    mStatus = 0; mErase = 0; mFail = 0; sr4 = 0; sr5 = 0;
    mPend = 0; mCnt = 0; mAddr = 0; mData = 0;
  endtask

  task automatic modelEdge(bit we, int a, int d, bit inj);
    bit wasBusy = (mCnt > 0);
    if (wasBusy) begin
      if (mCnt == 1) begin
        if (mErase) begin
          if (mFail) sr5 = 1;
          else for (int i = 0; i < DEPTH; i++)
            if ((i >> BLOCK_W) == (mAddr >> BLOCK_W)) mem[i] = 255;
        end else begin
          if (mFail) sr4 = 1;
          else begin
            int nv = mem[mAddr] & mData;
            if (nv != mData) sr4 = 1;
            mem[mAddr] = nv;
          end
        end
      end
      mCnt--;
    end
    if (we && !wasBusy) begin
      if (mPend == 1) begin
        mCnt = OP_LAT; mErase = 0; mAddr = a; mData = d; mFail = inj;
        mStatus = 1; mPend = 0;
      end else if (mPend == 2) begin
        if (d == 8'hD0) begin
          mCnt = OP_LAT; mErase = 1; mAddr = a; mData = d; mFail = inj;
        end else begin
          sr4 = 1; sr5 = 1;
        end
        mStatus = 1; mPend = 0;
      end else begin
        case (d)
          8'hFF: mStatus = 0;
          8'h70: mStatus = 1;
          8'h50: begin sr4 = 0; sr5 = 0; end
          8'h40: mPend = 1;
          8'h20: mPend = 2;
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare();
    int expD = expRead(int'(busAddr));
    bit expR = (mCnt == 0);
    vectors++;
    if (busRdata !== 8'(expD) || readyBusy !== expR) begin
      errors++;
      $display("FAIL %s: addr=%0d rdata=%02h readyBusy=%0b expected rdata=%02h readyBusy=%0b",
               curReq, busAddr, busRdata, readyBusy, expD, expR);
    end
  endtask

  task automatic step(bit we, int a, int d, bit inj);
    busWe = we; busAddr = ADDR_W'(a); busWdata = 8'(d); injectFail = inj;
    @(posedge clk);
    modelEdge(we, a, d, inj);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int d);
    step(1, a, d, 0);
  endtask

  task automatic rd(int a, int n);
    for (int i = 0; i < n; i++) step(0, (a + i) % DEPTH, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0; injectFail = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, every byte erased and ready
    curReq = "R1"; compare(); rd(0, DEPTH);
    // R3: status byte when idle with no errors
    curReq = "R3"; wr(0, 8'h70); rd(7, 3);
    // R2: array reads, persistent
    curReq = "R2"; wr(0, 8'hFF); rd(10, 4);
    // R12: unknown code ignored, still array mode
    curReq = "R12"; wr(0, 8'h33); rd(2, 3); wr(1, 8'h00); rd(2, 2);
    // R5 and R7: program, busy window
    curReq = "R5"; wr(0, 8'h40); curReq = "R7"; wr(5, 8'h12); rd(5, OP_LAT + 2);
    // R11: status persists after completion until 0xFF
    curReq = "R11"; rd(5, 3); wr(0, 8'h70); rd(5, 1); wr(0, 8'hFF); rd(4, 3);
    // program outside the later erase block
    curReq = "R5"; wr(0, 8'h40); wr(20, 8'h55); rd(20, OP_LAT + 1); wr(0, 8'hFF); rd(19, 3);
    // R8: writes during busy ignored
    curReq = "R8"; wr(0, 8'h40); wr(6, 8'h0F);
    wr(0, 8'hFF); wr(0, 8'h40); wr(6, 8'h00); rd(6, OP_LAT);
    wr(0, 8'hFF); rd(5, 3);
    // R10: attempt to set a 0 bit to 1 flags program error
    curReq = "R10"; wr(0, 8'h40); wr(5, 8'h13); rd(5, OP_LAT + 2);
    wr(0, 8'hFF); rd(5, 1);
    // R4: clear flags, mode unchanged
    curReq = "R4"; wr(0, 8'h50); rd(5, 2); wr(0, 8'h70); rd(0, 2);
    // R6: block erase by top address of block 0
    curReq = "R6"; wr(0, 8'h20); wr(15, 8'hD0); rd(0, OP_LAT + 2);
    wr(0, 8'hFF); rd(0, 24);
    // R9: bad confirm byte
    curReq = "R9"; wr(0, 8'h40); wr(40, 8'hA5); rd(40, OP_LAT + 1); wr(0, 8'hFF);
    wr(0, 8'h20); wr(47, 8'h11); rd(40, 3); wr(0, 8'hFF); rd(40, 2);
    wr(0, 8'h50);
    // R13: injected faults
    curReq = "R13"; wr(0, 8'h40); step(1, 40, 8'h00, 1); rd(40, OP_LAT + 2);
    wr(0, 8'h50); wr(0, 8'h20); step(1, 47, 8'hD0, 1); rd(40, OP_LAT + 2);
    wr(0, 8'hFF); rd(38, 4);
    // R6 again on block 2 after clearing flags
    curReq = "R6"; wr(0, 8'h50); wr(0, 8'h20); wr(33, 8'hD0); rd(30, OP_LAT + 1);
    wr(0, 8'hFF); rd(28, 24);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule